// File: doc/BRIEF.md
# Privileged control register bank

This block holds the 64-bit privileged control registers of a processor core. One read port and one write port address the bank by a 6-bit register index. A read returns in the same cycle. A write takes effect on the clock edge, and only when the write is committed, so speculative writes never change state.

Each register applies its own write rule. Some keep every bit. Some keep only a masked set of bits. One forces bit 1 to zero. Two are cleared by any write. The cycle-count register returns its stored upper half joined to a free-running 32-bit counter. A read of a write-only or undefined index raises an access error, and so does a write to a read-only or undefined index. In both cases the error arrives as a registered one-cycle pulse.

Top module: `ctlreg_bank`

## Requirements
- R1: After synchronous reset, every register reads zero with two exceptions. Index 8 (vector base) reads the parameter BASE_RESET and index 9 (machine control) reads 0x6. `acc_err` is low.
- R2: Indices 0..7 (scratch), 8, 9 and 27 (cycle, upper half) store the full written value.
- R3: Index 10 (exception address) stores the written value with bit 1 forced to zero.
- R4: Masked registers keep only the masked bits. The index and mask pairs are:
  - 11 and 12 (trap request/enable): 0xF
  - 13 (priority level): 0x1F
  - 14, 15 (mode) and write-only 32: 0x18
  - 16 (soft interrupt request): 0x7FFF0
  - 17 (instruction control): 0xFF_FFFF_0300
  - 18, 19 (page-table bases): bits [63:30]
  - 20 (cache test): 0x1FFB
  - 21, 22 (cache mode): 0x3F
  - 23 (instruction space id): 0x7F0
  - 24 (data space id): bits [63:57]
- R5: Any committed write to index 25 or 26 (exception summary and mask) clears that register, whatever the data.
- R6: A read of index 27 returns stored bits [63:32] joined to the low 32 bits of a counter. The counter is zero in the cycle after reset and advances by one every clock.
- R7: A read of write-only index 31 or 32, or of any index from 33 to 63, returns zero and raises the error.
- R8: A committed write to read-only index 28, 29 or 30, or to any index from 33 to 63, raises the error and changes no register.
- R9: A write with `wr_commit` low changes no register and raises no error.
- R10: `rd_data` follows `rd_idx` in the same cycle and is zero when `rd_en` is low. A committed write is visible to a read from the cycle after its clock edge.
- R11: `acc_err` is high for exactly the one cycle after the edge that sampled an illegal access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read request |
| rd_idx | input | 6 | Read register index |
| rd_data | output | 64 | Read value, combinational |
| wr_en | input | 1 | Write request |
| wr_commit | input | 1 | Write is non-speculative |
| wr_idx | input | 6 | Write register index |
| wr_data | input | 64 | Write value |
| acc_err | output | 1 | Illegal access pulse |

## Verification
The bench targets three groups of corner cases.

The first is the write masks, tested by writing all ones and then all zeros to each register. A wrong mask would leak bits into a read or drop bits the register should keep.

The second is a clear-on-write register written with random data, and a speculative write to every index. A bank that honoured either would show the written data on the next read.

The third is illegal accesses and back-to-back reads of the cycle register. A wrong error path would corrupt a register on a rejected write, or return non-zero data on a rejected read. A wrong composition would show a counter that does not advance by one per cycle, or a stale upper half.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;
  localparam int IDX_W  = 6;
  localparam int DATA_W = 64;
  localparam int NREG   = 33;
  localparam int CNT_W  = 32;

  localparam logic [IDX_W-1:0] IX_BASE   = 6'd8;
  localparam logic [IDX_W-1:0] IX_MCTL   = 6'd9;
  localparam logic [IDX_W-1:0] IX_EXCA   = 6'd10;
  localparam logic [IDX_W-1:0] IX_TRQ    = 6'd11;
  localparam logic [IDX_W-1:0] IX_TEN    = 6'd12;
  localparam logic [IDX_W-1:0] IX_PRIO   = 6'd13;
  localparam logic [IDX_W-1:0] IX_IMODE  = 6'd14;
  localparam logic [IDX_W-1:0] IX_DMODE  = 6'd15;
  localparam logic [IDX_W-1:0] IX_SOFT   = 6'd16;
  localparam logic [IDX_W-1:0] IX_ICTL   = 6'd17;
  localparam logic [IDX_W-1:0] IX_IPTB   = 6'd18;
  localparam logic [IDX_W-1:0] IX_DPTB   = 6'd19;
  localparam logic [IDX_W-1:0] IX_CTEST  = 6'd20;
  localparam logic [IDX_W-1:0] IX_CMODE  = 6'd21;
  localparam logic [IDX_W-1:0] IX_QMODE  = 6'd22;
  localparam logic [IDX_W-1:0] IX_ISPC   = 6'd23;
  localparam logic [IDX_W-1:0] IX_DSPC   = 6'd24;
  localparam logic [IDX_W-1:0] IX_XSUM   = 6'd25;
  localparam logic [IDX_W-1:0] IX_XMSK   = 6'd26;
  localparam logic [IDX_W-1:0] IX_CYC    = 6'd27;
  localparam logic [IDX_W-1:0] IX_ROID   = 6'd28;
  localparam logic [IDX_W-1:0] IX_ROMM   = 6'd29;
  localparam logic [IDX_W-1:0] IX_RORX   = 6'd30;
  localparam logic [IDX_W-1:0] IX_WOFL   = 6'd31;
  localparam logic [IDX_W-1:0] IX_WOALT  = 6'd32;

  localparam logic [DATA_W-1:0] MCTL_RESET = 64'h6;

  typedef struct packed {
    logic              readable;
    logic              writable;
    logic              is_cycle;
    logic [DATA_W-1:0] keep;
  } reg_attr_t;
endpackage

// File: rtl/ctlreg_attr.sv
module ctlreg_attr
  import ctlreg_pkg::*;
(
  input  logic [IDX_W-1:0] idx,
  output reg_attr_t        attr
);
  always_comb begin
    attr.readable = 1'b1;
    attr.writable = 1'b1;
    attr.is_cycle = 1'b0;
    attr.keep     = '1;
    if (idx >= IDX_W'(NREG)) begin
      attr.readable = 1'b0;
      attr.writable = 1'b0;
      attr.keep     = '0;
    end else begin
      unique case (idx)
        IX_EXCA:           attr.keep = ~64'h2;
        IX_TRQ, IX_TEN:    attr.keep = 64'hF;
        IX_PRIO:           attr.keep = 64'h1F;
        IX_IMODE, IX_DMODE: attr.keep = 64'h18;
        IX_SOFT:           attr.keep = 64'h7FFF0;
        IX_ICTL:           attr.keep = 64'hFF_FFFF_0300;
        IX_IPTB, IX_DPTB:  attr.keep = {34'h3_FFFF_FFFF, 30'h0};
        IX_CTEST:          attr.keep = 64'h1FFB;
        IX_CMODE, IX_QMODE: attr.keep = 64'h3F;
        IX_ISPC:           attr.keep = 64'h7F0;
        IX_DSPC:           attr.keep = {7'h7F, 57'h0};
        IX_XSUM, IX_XMSK:  attr.keep = '0;
        IX_CYC:            attr.is_cycle = 1'b1;
        IX_ROID, IX_ROMM, IX_RORX: begin
          attr.writable = 1'b0;
          attr.keep     = '0;
        end
        IX_WOFL:           attr.readable = 1'b0;
        IX_WOALT: begin
          attr.readable = 1'b0;
          attr.keep     = 64'h18;
        end
        default:           attr.keep = '1;
      endcase
    end
  end
endmodule

// File: rtl/ctlreg_cyc_ctr.sv
module ctlreg_cyc_ctr #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= count + 1'b1;
  end
endmodule

// File: rtl/ctlreg_bank.sv
module ctlreg_bank
  import ctlreg_pkg::*;
#(
  parameter logic [DATA_W-1:0] BASE_RESET = 64'h0000_0000_0000_4000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic              wr_commit,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic              acc_err
);
  localparam int HI = DATA_W - CNT_W;

  reg_attr_t         rd_attr, wr_attr;
  logic [CNT_W-1:0]  cyc_cnt;
  logic [DATA_W-1:0] store [NREG];
  logic [DATA_W-1:0] rd_raw;
  logic              wr_live, wr_ok, rd_bad, wr_bad;

  ctlreg_attr u_rd_attr (.idx(rd_idx), .attr(rd_attr));
  ctlreg_attr u_wr_attr (.idx(wr_idx), .attr(wr_attr));
  ctlreg_cyc_ctr #(.W(CNT_W)) u_ctr (.clk(clk), .rst(rst), .count(cyc_cnt));

  assign wr_live = wr_en && wr_commit;
  assign wr_ok   = wr_live && wr_attr.writable;
  assign wr_bad  = wr_live && !wr_attr.writable;
  assign rd_bad  = rd_en && !rd_attr.readable;

  for (genvar g = 0; g < NREG; g++) begin : g_slot
    localparam logic [DATA_W-1:0] RV =
      (g == int'(IX_BASE)) ? BASE_RESET :
      (g == int'(IX_MCTL)) ? MCTL_RESET : '0;
    always_ff @(posedge clk) begin
      if (rst)
        store[g] <= RV;
      else if (wr_ok && wr_idx == IDX_W'(g))
        store[g] <= wr_data & wr_attr.keep;
    end
  end

  always_comb begin
    rd_raw = '0;
    for (int i = 0; i < NREG; i++)
      if (rd_idx == IDX_W'(i)) rd_raw = store[i];
    if (!rd_en || !rd_attr.readable)
      rd_data = '0;
    else if (rd_attr.is_cycle)
      rd_data = {rd_raw[DATA_W-1 -: HI], cyc_cnt};
    else
      rd_data = rd_raw;
  end

  always_ff @(posedge clk) begin
    if (rst) acc_err <= 1'b0;
    else     acc_err <= rd_bad || wr_bad;
  end
endmodule

// File: rtl/ctlreg_bank_chk.sv
module ctlreg_bank_chk
  import ctlreg_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              rd_en,
  input logic [IDX_W-1:0]  rd_idx,
  input logic [DATA_W-1:0] rd_data,
  input logic              acc_err
);
  AST_ERR_LOW_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !acc_err);  // R1
  AST_EXCA_BIT1_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_idx == IX_EXCA) |-> !rd_data[1]);  // R3
  AST_PRIO_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_idx == IX_PRIO) |-> (rd_data[63:5] == '0));  // R4
  AST_SOFT_MASK: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_idx == IX_SOFT) |-> ((rd_data & ~64'h7FFF0) == '0));  // R4
  AST_CLEARED_REGS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (rd_idx == IX_XSUM || rd_idx == IX_XMSK)) |-> (rd_data == '0));  // R5
  AST_CYC_ADVANCES: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_idx == IX_CYC && $past(!rst && rd_en && rd_idx == IX_CYC))
      |-> (rd_data[31:0] == $past(rd_data[31:0]) + 32'd1));  // R6
  AST_BAD_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_idx >= IX_WOFL) |-> (rd_data == '0));  // R7
  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    !rd_en |-> (rd_data == '0));  // R10
endmodule

bind ctlreg_bank ctlreg_bank_chk i_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .rd_idx(rd_idx),
  .rd_data(rd_data), .acc_err(acc_err)
);

// File: tb/test_ctlreg_bank.sv
`timescale 1ns/1ps
module test_ctlreg_bank;
  localparam logic [63:0] BASE = 64'h0000_0000_0000_4000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_en = 0, wr_en = 0, wr_commit = 0;
  logic [5:0]  rd_idx = 0, wr_idx = 0;
  logic [63:0] wr_data = 0, rd_data;
  logic        acc_err;
  logic [31:0] cyc = 0;
  logic [63:0] model [64];
  int checks = 0, fails = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= rst ? 32'd0 : cyc + 32'd1;

  ctlreg_bank #(.BASE_RESET(BASE)) i_ctlreg_bank (.*);

  function automatic logic [63:0] mask_of(int ix);
    case (ix)
      10: return ~64'h2;
      11, 12: return 64'hF;
      13: return 64'h1F;
      14, 15, 32: return 64'h18;
      16: return 64'h7FFF0;
      17: return 64'hFF_FFFF_0300;
      18, 19: return 64'hFFFF_FFFF_C000_0000;
      20: return 64'h1FFB;
      21, 22: return 64'h3F;
      23: return 64'h7F0;
      24: return 64'hFE00_0000_0000_0000;
      25, 26: return 64'h0;
      default: return '1;
    endcase
  endfunction
  function automatic bit can_rd(int ix); return ix <= 30; endfunction
  function automatic bit can_wr(int ix); return !(ix >= 28 && ix <= 30) && ix <= 32; endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 64; i++) model[i] = '0;
    model[8] = BASE;
    model[9] = 64'h6;
  endtask

  // Starts and ends just after a falling edge.
  task automatic op(bit re, int ri, bit we, bit cm, int wi, logic [63:0] wd, string req);
    logic [63:0] e;
    bit ee;
    rd_en = re; rd_idx = 6'(ri); wr_en = we; wr_commit = cm; wr_idx = 6'(wi); wr_data = wd;
    #1;
    if (!re || !can_rd(ri)) e = '0;
    else if (ri == 27) e = {model[27][63:32], cyc};
    else e = model[ri];
    chk(rd_data === e, re ? req : "R10", rd_data, e);
    ee = (re && !can_rd(ri)) || (we && cm && !can_wr(wi));
    @(posedge clk);
    if (we && cm && can_wr(wi)) model[wi] = wd & mask_of(wi);
    @(negedge clk);
    rd_en = 0; wr_en = 0; wr_commit = 0;
    chk(acc_err === ee, "R11", {63'b0, acc_err}, {63'b0, ee});
  endtask

  initial begin
    #(4 * 150000);
    fails++; checks++;
    $display("FAIL watchdog actual=hang expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    chk(acc_err === 1'b0, "R1", {63'b0, acc_err}, 64'b0);
    for (int i = 0; i < 31; i++) op(1, i, 0, 0, 0, 0, "R1");
    // R2 full store, R3/R4 masks with all ones then zeros
    for (int i = 0; i < 33; i++) begin
      op(0, 0, 1, 1, i, '1, "R4");
      op(1, i, 0, 0, 0, 0, (i == 10) ? "R3" : (i <= 9) ? "R2" : "R4");
      op(0, 0, 1, 1, i, 64'h0, "R4");
      op(1, i, 0, 0, 0, 0, "R4");
    end
    // R5 clear on write
    op(0, 0, 1, 1, 25, 64'hDEAD_BEEF_1234_5678, "R5");
    op(1, 25, 1, 1, 26, 64'hFFFF, "R5");
    op(1, 26, 0, 0, 0, 0, "R5");
    // R6 cycle register composition, back-to-back reads
    op(0, 0, 1, 1, 27, 64'hA5A5_1234_FFFF_FFFF, "R6");
    for (int i = 0; i < 4; i++) op(1, 27, 0, 0, 0, 0, "R6");
    // R9 uncommitted writes change nothing
    for (int i = 0; i < 33; i++) op(0, 0, 1, 0, i, 64'h1357_9BDF_2468_ACE0, "R9");
    for (int i = 0; i < 31; i++) op(1, i, 0, 0, 0, 0, "R9");
    // R7 illegal reads, R8 illegal writes
    op(1, 31, 0, 0, 0, 0, "R7");
    op(1, 63, 1, 1, 28, '1, "R7");
    op(1, 28, 1, 1, 45, '1, "R8");
    op(1, 29, 1, 1, 30, 64'h77, "R8");
    op(1, 30, 0, 0, 0, 0, "R8");
    // R10 same-cycle read sees old value; next cycle sees new
    op(1, 0, 1, 1, 0, 64'h0123_4567_89AB_CDEF, "R10");
    op(1, 0, 0, 0, 0, 0, "R10");
    // random mix
    for (int n = 0; n < 3000; n++) begin
      int ri = int'($urandom % 40);
      int wi = int'($urandom % 40);
      op(bit'($urandom % 2), ri, bit'($urandom % 2), bit'(($urandom % 4) != 0), wi,
         {$urandom, $urandom}, "R4");
    end
    // reset in mid-run
    rst = 1;
    @(negedge clk); @(negedge clk);
    rst = 0; model_reset();
    for (int i = 0; i < 31; i++) op(1, i, 0, 0, 0, 0, "R1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule